// File: doc/BRIEF.md
# Strided Bit Gather Unit

The unit picks every Nth bit out of a 128-bit vector operand and packs the picked bits into a 64-bit scalar. N is a stride from 2 to 7 and is given with each request. Picking starts at the most significant operand bit. The picked bits fill the result from its most significant bit downward, in the order they were picked. Every result position left over is zero. Stride codes 0 and 1 are rejected: the result is zero and an error flag is raised. The operand is treated as one flat 128-bit value, so the way software splits it into lanes has no effect on the result.

A request is a single cycle with `req_valid` high, carrying the operand and the stride. The response appears on the next cycle as `rsp_valid` with the result and the error flag. There is no back-pressure, so a new request may be issued on every cycle. The response stage is a two-state machine. In `RSP_IDLE` no response is presented. In `RSP_VALID` a response is presented. The machine has four transitions:
- `IDLE_TO_VALID`: a request is seen while idle.
- `VALID_TO_VALID`: a request arrives on the cycle right after another.
- `VALID_TO_IDLE`: no request follows a response.
- `IDLE_HOLD`: the machine stays idle because no request arrives.

When no request arrives, the result and flag registers keep their last values. A synchronous reset puts the machine in `RSP_IDLE` and clears the result and the flag.

Top module: `stride_gather_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after a rising clock edge that sampled `req_valid` high. In every other cycle it is low.
- R2: Operand bits are numbered big-endian: index i means `req_operand[127-i]`. For a legal stride N, `rsp_result[63-k]` equals operand index k*N for every k with k*N < 128.
- R3: For a legal stride N, the lowest 64 - ceil(128/N) bits of `rsp_result` are zero. The number of picked bits is 64, 43, 32, 26, 22 and 19 for N = 2 to 7.
- R4: A stride code from 2 to 7 gives `rsp_bad_stride` = 0 in the response cycle.
- R5: A stride code of 0 or 1 gives `rsp_result` = 0 and `rsp_bad_stride` = 1, in the same cycle as `rsp_valid`.
- R6: In a cycle after an edge where `req_valid` was low, `rsp_result` and `rsp_bad_stride` keep their previous values.
- R7: A synchronous reset (`rst` = 1 at a rising edge) clears `rsp_valid`, `rsp_result` and `rsp_bad_stride`.
- R8: Requests on consecutive cycles each get their own response, in order, one per cycle.
- R9: Worked values:
  - stride 2 on an operand with upper 32 bits 0x88888888 and the rest zero gives 0xAAAA000000000000.
  - stride 4 on 0x80 in all 16 bytes gives 0xAAAAAAAA00000000.
  - stride 4 on 0x80 in the upper 8 bytes only gives 0xAAAA000000000000.
  - stride 2 on 0x88 in the upper 8 bytes gives 0xAAAAAAAA00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_operand | input | 128 | Source vector, bit 127 is big-endian index 0 |
| req_stride | input | 3 | Stride code, legal values 2 to 7 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_result | output | 64 | Picked bits, packed from the top, zero-filled below |
| rsp_bad_stride | output | 1 | High when the request used stride code 0 or 1 |

## Verification
A response state machine stuck in `RSP_IDLE` or `RSP_VALID` shows as a missing or extra `rsp_valid` on the very first cycle after a request, or after a gap. A wrongly wired gather lane shows as one wrong result bit in the response cycle. It only shows when the stride that uses that lane is selected and the operand bit it should carry differs from the bit it does carry. For that reason, single-bit and inverted single-bit operands are walked through every position for several strides. A stride decoder that accepts or rejects the wrong codes shows as a flipped `rsp_bad_stride` together with a nonzero or zero result in the same response cycle.

// File: rtl/gather_pkg.sv
package gather_pkg;

    localparam int GATHER_OP_W      = 128;
    localparam int GATHER_RES_W     = 64;
    localparam int GATHER_STRIDE_W  = 3;
    localparam int GATHER_MIN_STEP  = 2;
    localparam int GATHER_MAX_STEP  = 7;

    // Response stage: empty, or presenting a response.
    typedef enum logic {
        RSP_IDLE  = 1'b0,
        RSP_VALID = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/gather_stride_decode.sv
module gather_stride_decode #(
    parameter int STRIDE_W    = 3,
    parameter int MIN_STRIDE  = 2,
    parameter int NUM_STRIDES = 6
) (
    input  logic [STRIDE_W-1:0]    stride,
    output logic [NUM_STRIDES-1:0] sel_oh,
    output logic                   bad
);

    // One select line per legal stride; an illegal code lights none.
    for (genvar s = 0; s < NUM_STRIDES; s++) begin : g_sel
        assign sel_oh[s] = (stride == STRIDE_W'(MIN_STRIDE + s));
    end

    assign bad = ~|sel_oh;

endmodule

// File: rtl/gather_lanes.sv
module gather_lanes #(
    parameter int OP_W        = 128,
    parameter int RES_W       = 64,
    parameter int MIN_STRIDE  = 2,
    parameter int NUM_STRIDES = 6
) (
    input  logic [OP_W-1:0]        operand,
    input  logic [NUM_STRIDES-1:0] sel_oh,
    output logic [RES_W-1:0]       gathered
);

    // Result slot k (counted from the MSB) takes big-endian operand
    // index k*N. Each slot is an AND-OR over the candidate bits of
    // all legal strides; an all-zero select gives a zero slot.
    for (genvar k = 0; k < RES_W; k++) begin : g_slot
        logic [NUM_STRIDES-1:0] cand;
        for (genvar s = 0; s < NUM_STRIDES; s++) begin : g_step
            localparam int SRC = k * (MIN_STRIDE + s);
            if (SRC < OP_W) begin : g_take
                assign cand[s] = operand[OP_W-1-SRC];
            end else begin : g_fill
                assign cand[s] = 1'b0;
            end
        end
        assign gathered[RES_W-1-k] = |(cand & sel_oh);
    end

    // Indices that no legal stride reaches stay unconnected.
    logic unused_operand_bits;
    assign unused_operand_bits = ^operand;

endmodule

// File: rtl/gather_rsp_stage.sv
module gather_rsp_stage
    import gather_pkg::*;
#(
    parameter int RES_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [RES_W-1:0] in_result,
    input  logic             in_bad,
    output logic             out_valid,
    output logic [RES_W-1:0] out_result,
    output logic             out_bad
);

    rsp_state_e state_q;
    rsp_state_e state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RSP_IDLE:  state_nx = in_valid ? RSP_VALID : RSP_IDLE;
            RSP_VALID: state_nx = in_valid ? RSP_VALID : RSP_IDLE;
            default:   state_nx = RSP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Output register: loads only on a request, holds otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            out_result <= '0;
            out_bad    <= 1'b0;
        end else if (in_valid) begin
            out_result <= in_result;
            out_bad    <= in_bad;
        end
    end

    assign out_valid = (state_q == RSP_VALID);

endmodule

// File: rtl/stride_gather_unit.sv
module stride_gather_unit
    import gather_pkg::*;
#(
    parameter int OP_W       = GATHER_OP_W,
    parameter int RES_W      = GATHER_RES_W,
    parameter int STRIDE_W   = GATHER_STRIDE_W,
    parameter int MIN_STRIDE = GATHER_MIN_STEP,
    parameter int MAX_STRIDE = GATHER_MAX_STEP
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [OP_W-1:0]     req_operand,
    input  logic [STRIDE_W-1:0] req_stride,
    output logic                rsp_valid,
    output logic [RES_W-1:0]    rsp_result,
    output logic                rsp_bad_stride
);

    localparam int NUM_STRIDES = MAX_STRIDE - MIN_STRIDE + 1;

    logic [NUM_STRIDES-1:0] sel_oh;
    logic                   bad;
    logic [RES_W-1:0]       gathered;

    gather_stride_decode #(
        .STRIDE_W    (STRIDE_W),
        .MIN_STRIDE  (MIN_STRIDE),
        .NUM_STRIDES (NUM_STRIDES)
    ) u_decode (
        .stride (req_stride),
        .sel_oh (sel_oh),
        .bad    (bad)
    );

    gather_lanes #(
        .OP_W        (OP_W),
        .RES_W       (RES_W),
        .MIN_STRIDE  (MIN_STRIDE),
        .NUM_STRIDES (NUM_STRIDES)
    ) u_lanes (
        .operand  (req_operand),
        .sel_oh   (sel_oh),
        .gathered (gathered)
    );

    gather_rsp_stage #(
        .RES_W (RES_W)
    ) u_rsp (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (req_valid),
        .in_result  (gathered),
        .in_bad     (bad),
        .out_valid  (rsp_valid),
        .out_result (rsp_result),
        .out_bad    (rsp_bad_stride)
    );

endmodule

// File: rtl/stride_gather_unit_chk.sv
module stride_gather_unit_chk #(
    parameter int OP_W       = 128,
    parameter int RES_W      = 64,
    parameter int STRIDE_W   = 3,
    parameter int MIN_STRIDE = 2,
    parameter int MAX_STRIDE = 7
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [OP_W-1:0]     req_operand,
    input logic [STRIDE_W-1:0] req_stride,
    input logic                rsp_valid,
    input logic [RES_W-1:0]    rsp_result,
    input logic                rsp_bad_stride
);

    logic req_legal;
    assign req_legal = (int'(req_stride) >= MIN_STRIDE) && (int'(req_stride) <= MAX_STRIDE);

    // Positions below the last picked bit for stride s.
    function automatic logic [RES_W-1:0] tail_mask(input logic [STRIDE_W-1:0] s);
        int cnt;
        if (s == '0) return '1;
        cnt = (OP_W + int'(s) - 1) / int'(s);
        if (cnt >= RES_W) return '0;
        return {RES_W{1'b1}} >> cnt;
    endfunction

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R2
    first_bit_from_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_legal) |=> rsp_result[RES_W-1] == $past(req_operand[OP_W-1]));

    // R2
    second_bit_one_stride_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_legal) |=>
            rsp_result[RES_W-2] == $past(req_operand[OP_W-1-int'(req_stride)]));

    // R3
    zero_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_legal) |=> (rsp_result & tail_mask($past(req_stride))) == '0);

    // R4
    legal_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_legal) |=> !rsp_bad_stride);

    // R5
    illegal_flag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_legal) |=> (rsp_bad_stride && rsp_valid && rsp_result == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_result) && $stable(rsp_bad_stride)));

endmodule

bind stride_gather_unit stride_gather_unit_chk #(
    .OP_W       (OP_W),
    .RES_W      (RES_W),
    .STRIDE_W   (STRIDE_W),
    .MIN_STRIDE (MIN_STRIDE),
    .MAX_STRIDE (MAX_STRIDE)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_operand    (req_operand),
    .req_stride     (req_stride),
    .rsp_valid      (rsp_valid),
    .rsp_result     (rsp_result),
    .rsp_bad_stride (rsp_bad_stride)
);

// File: tb/stride_gather_unit_bench.sv
module stride_gather_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic [127:0] req_operand;
    logic [2:0]   req_stride;
    logic         rsp_valid;
    logic [63:0]  rsp_result;
    logic         rsp_bad_stride;

    always #2 clk = ~clk;

    stride_gather_unit u_stride_gather_unit (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_operand    (req_operand),
        .req_stride     (req_stride),
        .rsp_valid      (rsp_valid),
        .rsp_result     (rsp_result),
        .rsp_bad_stride (rsp_bad_stride)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_res_q[$];
    logic        exp_bad_q[$];
    string       tag_q[$];

    logic [63:0] last_res;
    logic        last_bad;

    function automatic logic [63:0] model(input logic [127:0] op, input int n);
        logic [63:0] r = '0;
        if (n < 2 || n > 7) return '0;
        for (int k = 0; k < 64; k++) begin
            if (k * n < 128) r[63-k] = op[127-k*n];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_req(input logic [127:0] op, input logic [2:0] s,
                            input logic [63:0] exp, input logic bad, input string tag);
        @(negedge clk);
        req_valid   = 1'b1;
        req_operand = op;
        req_stride  = s;
        exp_res_q.push_back(exp);
        exp_bad_q.push_back(bad);
        tag_q.push_back(tag);
    endtask

    task automatic send(input logic [127:0] op, input logic [2:0] s, input string tag);
        push_req(op, s, model(op, int'(s)), (s < 3'd2), tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compares responses against the scoreboard queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                last_res = rsp_result;
                last_bad = rsp_bad_stride;
            end else if (rsp_valid) begin
                if (exp_res_q.size() == 0) begin
                    check(1'b0, "R1 unexpected response", {63'd0, rsp_valid}, 64'd0);
                end else begin
                    logic [63:0] e_res;
                    logic        e_bad;
                    string       t;
                    e_res = exp_res_q.pop_front();
                    e_bad = exp_bad_q.pop_front();
                    t     = tag_q.pop_front();
                    check(rsp_result == e_res, {t, " result"}, rsp_result, e_res);
                    check(rsp_bad_stride == e_bad, {t, " flag"},
                          {63'd0, rsp_bad_stride}, {63'd0, e_bad});
                end
                last_res = rsp_result;
                last_bad = rsp_bad_stride;
            end else begin
                if (exp_res_q.size() != 0) begin
                    check(1'b0, "R1 missing response", {63'd0, rsp_valid}, 64'd1);
                    void'(exp_res_q.pop_front());
                    void'(exp_bad_q.pop_front());
                    void'(tag_q.pop_front());
                end
                check(rsp_result == last_res && rsp_bad_stride == last_bad,
                      "R6 hold while idle", rsp_result, last_res);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        req_valid   = 1'b0;
        req_operand = '0;
        req_stride  = '0;
        repeat (2) @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R7 reset valid", {63'd0, rsp_valid}, 64'd0);
        check(rsp_result == 64'd0, "R7 reset result", rsp_result, 64'd0);
        check(rsp_bad_stride == 1'b0, "R7 reset flag", {63'd0, rsp_bad_stride}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9 worked values (back to back, which also covers R8)
        push_req({32'h88888888, 96'h0}, 3'd2, 64'hAAAA000000000000, 1'b0, "R9 s2 upper32");
        push_req({16{8'h80}},           3'd4, 64'hAAAAAAAA00000000, 1'b0, "R9 s4 all bytes");
        push_req({{8{8'h80}}, 64'h0},   3'd4, 64'hAAAA000000000000, 1'b0, "R9 s4 upper bytes");
        push_req({{8{8'h88}}, 64'h0},   3'd2, 64'hAAAAAAAA00000000, 1'b0, "R9 s2 upper64");
        idle(2);

        // R5 illegal codes, including right after a full legal result
        push_req({128{1'b1}}, 3'd0, 64'd0, 1'b1, "R5 stride0");
        send({128{1'b1}}, 3'd7, "R3 all ones s7");
        push_req({128{1'b1}}, 3'd1, 64'd0, 1'b1, "R5 stride1");
        idle(1);

        // R3 / R4 all-ones and all-zeros for every legal stride
        for (int s = 2; s < 8; s++) send({128{1'b1}}, 3'(s), "R3 all ones");
        for (int s = 2; s < 8; s++) send('0, 3'(s), "R4 all zeros");
        idle(1);

        // R2 walking single bits
        for (int i = 0; i < 128; i++) send(128'd1 << i, 3'd3, "R2 single s3");
        for (int i = 0; i < 128; i++) send(128'd1 << i, 3'd7, "R2 single s7");
        for (int i = 0; i < 128; i++) send(~(128'd1 << i), 3'd5, "R2 inverted s5");
        idle(2);

        // R8 random operands with random gaps
        for (int s = 2; s < 8; s++) begin
            for (int j = 0; j < 40; j++) begin
                send({$urandom, $urandom, $urandom, $urandom}, 3'(s), "R8 random");
                if ($urandom % 3 == 0) idle(1);
            end
        end
        for (int j = 0; j < 60; j++) begin
            send({$urandom, $urandom, $urandom, $urandom}, 3'($urandom % 8), "R4 random code");
        end
        idle(3);

        // R7 reset after a nonzero result
        send({128{1'b1}}, 3'd2, "R7 preload");
        idle(2);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R7 mid reset valid", {63'd0, rsp_valid}, 64'd0);
        check(rsp_result == 64'd0, "R7 mid reset result", rsp_result, 64'd0);
        check(rsp_bad_stride == 1'b0, "R7 mid reset flag", {63'd0, rsp_bad_stride}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        idle(3);

        check(exp_res_q.size() == 0, "R8 drained", 64'(exp_res_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule